// File: doc/BRIEF.md
# Interrupt Log Ring Writer

This block turns interrupt events into entries of a fixed ring in shared RAM and raises a host interrupt pin for each entry it records. An event is offered with a one-cycle commit strobe, a vector of cause bits and an event address word. The cause bits are gated by an enable mask; whatever survives is stored as a single identification word, so causes that coincide share one entry and one interrupt assertion.

Every entry is two words: the identification word at an even address and the event address word directly above it. The ring holds sixteen entries in the 32 words from 0x0040 to 0x005F. The block writes both words on consecutive cycles through a simple write port (enable, address, data) and only then moves its host-visible log pointer to the new entry. The host therefore never sees a half-written entry as the latest one. The interrupt pin is either a level that holds until acknowledged or a pulse of fixed length.

Top module: `intlog_writer`

## Requirements
- R1: After reset, `ram_we` and `irq_o` are low and `log_ptr` reads 0x005E, the last slot of the ring, so that the first entry is written at 0x0040.
- R2: When `evt_valid` is high at a clock edge while the block is idle and `evt_cause & cause_en` is nonzero, the identification word is written at the next even slot address: `ram_we` is high with that address from the following cycle on.
- R3: The identification word equals `evt_cause & cause_en`; several set bits are kept together in one entry.
- R4: A strobe whose masked cause is zero writes nothing and leaves `log_ptr` and `irq_o` unchanged.
- R5: In the cycle after the identification word, the event address word captured with the strobe is written at the slot address plus one.
- R6: One cycle after the address word, `ram_we` falls, `log_ptr` takes the slot address of the new entry and the interrupt fires, all on the same edge.
- R7: Consecutive entries use slot addresses rising by 2; after the entry at 0x005E the next one is written at 0x0040.
- R8: Strobes sampled on the two edges after an accepted strobe (while its entry is being written) are ignored: they cause no further RAM write and no extra pointer step.
- R9: With `irq_level_mode` high, `irq_o` stays high after an entry until `irq_ack` is sampled high; it is low from the following cycle.
- R10: With `irq_level_mode` low, `irq_o` is high for exactly PULSE_LEN (default 4) cycles per entry and `irq_ack` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | One-cycle commit strobe for an event |
| evt_cause | input | 16 | Cause bits of the event |
| evt_addr | input | 16 | Event address word stored in the second word of the entry |
| cause_en | input | 16 | Per-cause enable mask |
| irq_level_mode | input | 1 | 1: level interrupt held until acknowledge, 0: fixed pulse |
| irq_ack | input | 1 | Host acknowledge for the level interrupt |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 15 | RAM word address |
| ram_wdata | output | 16 | RAM write data |
| log_ptr | output | 15 | Address of the most recently completed entry |
| irq_o | output | 1 | Host interrupt pin |

## Verification
All results are registered, so for a strobe sampled at edge k the identification word is on the write port after edge k, the address word after edge k+1, and the pointer, the falling write enable and the interrupt after edge k+2. Each scenario task drives inputs on the falling edge and samples once per falling edge, checking exactly those three cycles in turn, and for ignored strobes it checks the idle write port and pointer in the cycle where an extra write would otherwise appear. Pulse length is counted one falling edge at a time, and acknowledge takes effect one cycle after it is sampled.

// File: rtl/intlog_pkg.sv
package intlog_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WR_ID = 2'd1,
    ST_WR_AD = 2'd2
  } wr_state_t;
endpackage

// File: rtl/intlog_ring_ptr.sv
module intlog_ring_ptr #(
  parameter int ADDR_W   = 15,
  parameter int LOG_BASE = 'h40,
  parameter int ENTRIES  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              commit,
  input  logic [ADDR_W-1:0] commit_addr,
  output logic [ADDR_W-1:0] next_addr,
  output logic [ADDR_W-1:0] log_ptr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);
  localparam logic [ADDR_W-1:0] LAST_SLOT = ADDR_W'(LOG_BASE + 2 * (ENTRIES - 1));

  logic [IDX_W-1:0] idx_q;

  assign next_addr = ADDR_W'(LOG_BASE) + ADDR_W'({idx_q, 1'b0});

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      log_ptr <= LAST_SLOT;
    end else begin
      if (adv) begin
        if (idx_q == LAST_IDX) idx_q <= '0;
        else                   idx_q <= idx_q + 1'b1;
      end
      if (commit) log_ptr <= commit_addr;
    end
  end

  // R7: the visible pointer always names an even slot inside the ring
  a_r7_ptr_in_ring: assert property (@(posedge clk) disable iff (rst)
    (log_ptr >= ADDR_W'(LOG_BASE)) && (log_ptr <= LAST_SLOT) && !log_ptr[0]);

  // R7: an advance from the last slot wraps to the base
  a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
    adv && (next_addr == LAST_SLOT) |=> next_addr == ADDR_W'(LOG_BASE));
endmodule

// File: rtl/intlog_irq_gen.sv
module intlog_irq_gen #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic level_mode,
  input  logic ack,
  output logic irq_o
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      cnt_q <= '0;
    end else if (level_mode) begin
      cnt_q <= '0;
      if (fire)     irq_o <= 1'b1;
      else if (ack) irq_o <= 1'b0;
    end else begin
      if (fire) begin
        irq_o <= 1'b1;
        cnt_q <= CNT_W'(PULSE_LEN);
      end else if (cnt_q > CNT_W'(1)) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        irq_o <= 1'b0;
        cnt_q <= '0;
      end
    end
  end

  // R9: a level interrupt is held until acknowledged
  a_r9_level_hold: assert property (@(posedge clk) disable iff (rst)
    level_mode && irq_o && !ack |=> irq_o);

  // R10: the pulse counter never exceeds the programmed length
  a_r10_pulse_bound: assert property (@(posedge clk) disable iff (rst)
    !level_mode |-> cnt_q <= CNT_W'(PULSE_LEN));

  // R10: in pulse mode the pin is high only while the counter runs
  a_r10_pulse_cnt: assert property (@(posedge clk) disable iff (rst)
    !level_mode && !fire && irq_o |=> (irq_o == ($past(cnt_q) > CNT_W'(1))));
endmodule

// File: rtl/intlog_writer.sv
module intlog_writer #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 16,
  parameter int LOG_BASE  = 'h40,
  parameter int ENTRIES   = 16,
  parameter int PULSE_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid,
  input  logic [DATA_W-1:0] evt_cause,
  input  logic [DATA_W-1:0] evt_addr,
  input  logic [DATA_W-1:0] cause_en,
  input  logic              irq_level_mode,
  input  logic              irq_ack,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic [ADDR_W-1:0] log_ptr,
  output logic              irq_o
);
  import intlog_pkg::*;

  localparam logic [ADDR_W-1:0] RING_LO = ADDR_W'(LOG_BASE);
  localparam logic [ADDR_W-1:0] RING_HI = ADDR_W'(LOG_BASE + 2 * ENTRIES - 1);

  wr_state_t         state_q;
  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] addr_word_q;
  logic              accept;
  logic              commit;
  logic [ADDR_W-1:0] next_addr;
  logic [ADDR_W-1:0] commit_addr;

  assign masked      = evt_cause & cause_en;
  assign accept      = (state_q == ST_IDLE) && evt_valid && (|masked);
  assign commit      = (state_q == ST_WR_AD);
  assign commit_addr = ram_addr - ADDR_W'(1);

  intlog_ring_ptr #(
    .ADDR_W  (ADDR_W),
    .LOG_BASE(LOG_BASE),
    .ENTRIES (ENTRIES)
  ) ptr_i (
    .clk        (clk),
    .rst        (rst),
    .adv        (accept),
    .commit     (commit),
    .commit_addr(commit_addr),
    .next_addr  (next_addr),
    .log_ptr    (log_ptr)
  );

  intlog_irq_gen #(
    .PULSE_LEN(PULSE_LEN)
  ) irq_i (
    .clk       (clk),
    .rst       (rst),
    .fire      (commit),
    .level_mode(irq_level_mode),
    .ack       (irq_ack),
    .irq_o     (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      ram_we      <= 1'b0;
      ram_addr    <= RING_LO;
      ram_wdata   <= '0;
      addr_word_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q     <= ST_WR_ID;
            ram_we      <= 1'b1;
            ram_addr    <= next_addr;
            ram_wdata   <= masked;
            addr_word_q <= evt_addr;
          end
        end
        ST_WR_ID: begin
          state_q   <= ST_WR_AD;
          ram_addr  <= ram_addr + ADDR_W'(1);
          ram_wdata <= addr_word_q;
        end
        ST_WR_AD: begin
          state_q <= ST_IDLE;
          ram_we  <= 1'b0;
        end
        default: begin
          state_q <= ST_IDLE;
          ram_we  <= 1'b0;
        end
      endcase
    end
  end

  // R2: identification words are never empty
  a_r2_id_nonzero: assert property (@(posedge clk) disable iff (rst)
    ram_we && !ram_addr[0] |-> ram_wdata != '0);

  // R5: the address word follows the identification word one address up
  a_r5_addr_follows: assert property (@(posedge clk) disable iff (rst)
    ram_we && !ram_addr[0] |=> ram_we && (ram_addr == $past(ram_addr) + ADDR_W'(1)));

  // R6: the pointer names the entry whose address word was just written
  a_r6_ptr_after_pair: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_we) |-> log_ptr == $past(ram_addr) - ADDR_W'(1));

  // R7: writes stay inside the ring
  a_r7_write_in_ring: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_addr >= RING_LO) && (ram_addr <= RING_HI));

  // R8: an entry never takes more than two write cycles
  a_r8_two_writes: assert property (@(posedge clk) disable iff (rst)
    ram_we && ram_addr[0] |=> !ram_we);
endmodule

// File: tb/intlog_writer_tb.sv
module intlog_writer_tb_top;
  localparam int AW = 15;
  localparam int DW = 16;
  localparam int PULSE = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          evt_valid = 1'b0;
  logic [DW-1:0] evt_cause = '0;
  logic [DW-1:0] evt_addr = '0;
  logic [DW-1:0] cause_en = '0;
  logic          irq_level_mode = 1'b1;
  logic          irq_ack = 1'b0;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [AW-1:0] log_ptr;
  logic          irq_o;

  int checks = 0;
  int errors = 0;
  int next_slot = 'h40;

  always #5 clk = ~clk;

  intlog_writer dut_i (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_cause(evt_cause),
    .evt_addr(evt_addr), .cause_en(cause_en), .irq_level_mode(irq_level_mode),
    .irq_ack(irq_ack), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .log_ptr(log_ptr), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int slot_after(input int s);
    return (s == 'h5E) ? 'h40 : s + 2;
  endfunction

  // strobe for one cycle, then check the two writes, pointer and interrupt
  task automatic do_entry(input logic [DW-1:0] c, input logic [DW-1:0] en,
                          input logic [DW-1:0] a);
    int slot = next_slot;
    evt_valid = 1'b1; evt_cause = c; cause_en = en; evt_addr = a;
    @(negedge clk);
    evt_valid = 1'b0;
    chk(ram_we == 1'b1, "R2 id write enable", ram_we, 1);
    chk(ram_addr == AW'(slot), "R2 id slot address", ram_addr, slot);
    chk(ram_wdata == (c & en), "R3 id word masked", ram_wdata, c & en);
    @(negedge clk);
    chk(ram_we == 1'b1 && ram_addr == AW'(slot + 1), "R5 address word location", ram_addr, slot + 1);
    chk(ram_wdata == a, "R5 address word data", ram_wdata, a);
    @(negedge clk);
    chk(ram_we == 1'b0, "R6 write ends", ram_we, 0);
    chk(log_ptr == AW'(slot), "R6 pointer update", log_ptr, slot);
    chk(irq_o == 1'b1, "R6 interrupt fires with pointer", irq_o, 1);
    next_slot = slot_after(slot);
  endtask

  task automatic do_ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk(irq_o == 1'b0, "R9 ack clears level", irq_o, 0);
  endtask

  task automatic t_reset();
    chk(ram_we == 1'b0, "R1 reset write idle", ram_we, 0);
    chk(irq_o == 1'b0, "R1 reset irq low", irq_o, 0);
    chk(log_ptr == AW'('h5E), "R1 reset pointer", log_ptr, 'h5E);
  endtask

  task automatic t_multi_cause();
    do_entry(16'h0011, 16'hFFFF, 16'h1234);
    do_ack();
  endtask

  task automatic t_masked_zero();
    int p = int'(log_ptr);
    evt_valid = 1'b1; evt_cause = 16'h0100; cause_en = 16'h00FF;
    @(negedge clk);
    evt_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(ram_we == 1'b0, "R4 masked event no write", ram_we, 0);
      chk(log_ptr == AW'(p), "R4 masked event pointer", log_ptr, p);
      chk(irq_o == 1'b0, "R4 masked event no irq", irq_o, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_partial_mask();
    do_entry(16'h0301, 16'h0300, 16'hBEEF);
    do_ack();
  endtask

  task automatic t_level_hold();
    do_entry(16'h8000, 16'hFFFF, 16'h0042);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(irq_o == 1'b1, "R9 level held", irq_o, 1);
    end
    do_ack();
  endtask

  task automatic t_busy();
    int slot = next_slot;
    evt_valid = 1'b1; evt_cause = 16'h0004; cause_en = 16'hFFFF; evt_addr = 16'h0A0A;
    @(negedge clk);
    chk(ram_addr == AW'(slot), "R8 first strobe accepted", ram_addr, slot);
    @(negedge clk);
    evt_cause = 16'h0008; evt_addr = 16'h0B0B;
    chk(ram_wdata == 16'h0A0A, "R8 address word not replaced", ram_wdata, 'h0A0A);
    @(negedge clk);
    evt_valid = 1'b0;
    chk(log_ptr == AW'(slot), "R8 pointer single step", log_ptr, slot);
    @(negedge clk);
    chk(ram_we == 1'b0, "R8 busy strobes no write", ram_we, 0);
    @(negedge clk);
    chk(ram_we == 1'b0 && log_ptr == AW'(slot), "R8 no late entry", log_ptr, slot);
    next_slot = slot_after(slot);
    do_ack();
  endtask

  task automatic t_wrap();
    while (next_slot != 'h40) begin
      do_entry(16'h0002, 16'hFFFF, DW'(next_slot));
      do_ack();
    end
    do_entry(16'h0040, 16'hFFFF, 16'h7777);
    chk(log_ptr == AW'('h40), "R7 wrap to base", log_ptr, 'h40);
    do_ack();
  endtask

  task automatic t_pulse();
    irq_level_mode = 1'b0;
    @(negedge clk);
    do_entry(16'h0020, 16'hFFFF, 16'h5555);
    irq_ack = 1'b1;
    for (int i = 1; i < PULSE; i++) begin
      @(negedge clk);
      chk(irq_o == 1'b1, "R10 pulse high", irq_o, 1);
    end
    irq_ack = 1'b0;
    @(negedge clk);
    chk(irq_o == 1'b0, "R10 pulse ends", irq_o, 0);
    @(negedge clk);
    chk(irq_o == 1'b0, "R10 pulse stays low", irq_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_multi_cause();
    t_masked_zero();
    t_partial_mask();
    t_level_hold();
    t_busy();
    t_wrap();
    t_pulse();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0x1 expected=0x0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule